// File: doc/BRIEF.md
# Pipelined Radix-2 Butterfly for Inverse FFT Stages

This block computes one radix-2 butterfly of an inverse FFT on complex fixed-point samples. It takes two samples `a` and `b`, each with signed real and imaginary parts of `DW` bits. It returns the sum `c = a + bW` and the difference `d = a - bW`. Each sample's real and imaginary parts are handled separately. The block is meant to be placed many times inside a fully parallel transform. Each copy is fixed at elaboration to the kind of stage it serves.

A general stage receives the twiddle product `bW` already formed and scaled by `2^TS`. The block rescales it by dropping the `TS` low bits, then sign-extends `a` and adds or subtracts, so the outputs are `DW+2` bits wide. A unity stage has a twiddle of exactly 1 and uses `b` directly. A quarter stage has a twiddle of 1 or j, chosen per sample by `rot_j`, and forms `jb` by swapping the parts and negating one. Neither of these two stages uses a multiplier, and both produce `DW+1`-bit outputs.

An optional limiter can narrow each output part to `LIM_W` bits. It either saturates to the signed range or drops low bits. It never rounds. All results pass through one register stage, and `out_valid` follows `in_valid` with the same latency.

Top module: `radix2_bfly_core`

## Requirements
- R1: In general mode, with P the signed `DW+TS+1`-bit product input and T = floor(P / 2^TS), the outputs are c = a + T and d = a - T per part, `DW+2` bits wide, with no limiter.
- R2: The rescale of P is a truncation toward minus infinity, not a rounding: P = -1 gives T = -1, and P = 2^TS - 1 gives T = 0.
- R3: In general mode, full-scale inputs (a = -2^(DW-1) or 2^(DW-1)-1 with T = -2^DW or 2^DW-1) give exact results with no wrap, and c + d equals 2a for every accepted sample.
- R4: In unity mode the product inputs and `rot_j` have no effect; c = a + b and d = a - b, `DW+1` bits before any limiter.
- R5: In quarter mode `rot_j = 0` uses the term b, and `rot_j = 1` uses jb: real part -b_im, imaginary part b_re. Both give `DW+1`-bit results before any limiter.
- R6: With the saturating limiter, each output part equals the exact result clamped to [-2^(LIM_W-1), 2^(LIM_W-1)-1].
- R7: With the truncating limiter, each output part equals floor(exact / 2^(N-LIM_W)), where N is the natural width of the mode.
- R8: `out_valid` and the data outputs for a sample appear on the first rising edge after the sample is presented with `in_valid` high.
- R9: A cycle with `in_valid` low does not change the data outputs; it drives `out_valid` low on the next edge.
- R10: While `rst_n` is low, `out_valid` and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| a_re | input | DW | Real part of a, signed |
| a_im | input | DW | Imaginary part of a, signed |
| b_re | input | DW | Real part of b, signed (unity and quarter modes) |
| b_im | input | DW | Imaginary part of b, signed (unity and quarter modes) |
| prod_re | input | DW+TS+1 | Real part of b times twiddle scaled by 2^TS (general mode) |
| prod_im | input | DW+TS+1 | Imaginary part of the scaled product (general mode) |
| rot_j | input | 1 | Quarter mode: 1 selects twiddle j, 0 selects twiddle 1 |
| out_valid | output | 1 | Output sample present |
| c_re | output | OW | Real part of a + bW |
| c_im | output | OW | Imaginary part of a + bW |
| d_re | output | OW | Real part of a - bW |
| d_im | output | OW | Imaginary part of a - bW |

## Verification
The bench drives negative products whose dropped bits are nonzero. A design that rounded, or that shifted logically instead of arithmetically, would be off by one or would turn a small negative term into a large positive one. It applies a = -2^(DW-1) together with extreme products, where forgetting to sign-extend a, or sizing the sum one bit short, makes c or d wrap to the wrong sign. In quarter mode it feeds b_im = -2^(DW-1) with `rot_j` high, which exposes a negation done at `DW` bits or a swap with the wrong part negated. It also drives sums just past the limiter range, where a wrapping limiter or one that keeps the high bits with the wrong offset gives visibly wrong codes.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Which kind of butterfly stage an instance serves.
    typedef enum logic [1:0] {
        SM_GENERAL = 2'd0,   // external scaled twiddle product
        SM_UNITY   = 2'd1,   // twiddle fixed at 1
        SM_QUARTER = 2'd2    // twiddle 1 or j per sample
    } stage_mode_e;

    // Output word-limit policy.
    typedef enum logic [1:0] {
        LIM_NONE  = 2'd0,
        LIM_SAT   = 2'd1,
        LIM_TRUNC = 2'd2
    } limit_e;

    // Natural result width for a mode: general stages grow two bits,
    // multiplier-free stages grow one.
    function automatic int nat_width(stage_mode_e mode, int dw);
        return (mode == SM_GENERAL) ? dw + 2 : dw + 1;
    endfunction

endpackage

// File: rtl/bfly_term_gen.sv
// Produces the term bW at the scale of a, DW+1 bits signed.
module bfly_term_gen #(
    parameter int                    DW   = 8,
    parameter int                    TS   = 7,
    parameter bfly_pkg::stage_mode_e MODE = bfly_pkg::SM_GENERAL
) (
    input  logic signed [DW-1:0]    b_re,
    input  logic signed [DW-1:0]    b_im,
    input  logic signed [DW+TS:0]   prod_re,
    input  logic signed [DW+TS:0]   prod_im,
    input  logic                    rot_j,
    output logic signed [DW:0]      t_re,
    output logic signed [DW:0]      t_im
);
    localparam int PW = DW + TS + 1;

    generate
        if (MODE == bfly_pkg::SM_GENERAL) begin : g_general
            logic signed [PW-1:0] sh_re;
            logic signed [PW-1:0] sh_im;
            always_comb begin
                sh_re = prod_re >>> TS;
                sh_im = prod_im >>> TS;
                t_re  = sh_re[DW:0];
                t_im  = sh_im[DW:0];
            end
        end else if (MODE == bfly_pkg::SM_QUARTER) begin : g_quarter
            logic signed [DW:0] bx_re;
            logic signed [DW:0] bx_im;
            always_comb begin
                bx_re = {b_re[DW-1], b_re};
                bx_im = {b_im[DW-1], b_im};
                if (rot_j) begin
                    t_re = -bx_im;
                    t_im = bx_re;
                end else begin
                    t_re = bx_re;
                    t_im = bx_im;
                end
            end
        end else begin : g_unity
            always_comb begin
                t_re = {b_re[DW-1], b_re};
                t_im = {b_im[DW-1], b_im};
            end
        end
    endgenerate
endmodule

// File: rtl/bfly_addsub.sv
// Sign-extends a and the term to SW bits and forms sum and difference.
module bfly_addsub #(
    parameter int DW = 8,
    parameter int SW = 10
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW:0]   t,
    output logic signed [SW-1:0] sum_o,
    output logic signed [SW-1:0] dif_o
);
    localparam int AX = SW - DW;
    localparam int TX = SW - DW - 1;

    logic signed [SW-1:0] a_x;
    logic signed [SW-1:0] t_x;

    always_comb begin
        a_x   = {{AX{a[DW-1]}}, a};
        t_x   = {{TX{t[DW]}}, t};
        sum_o = a_x + t_x;
        dif_o = a_x - t_x;
    end
endmodule

// File: rtl/bfly_out_limit.sv
// Narrows one output part by the selected policy.
module bfly_out_limit #(
    parameter int               IW     = 10,
    parameter int               OW     = 10,
    parameter bfly_pkg::limit_e POLICY = bfly_pkg::LIM_NONE
) (
    input  logic signed [IW-1:0] x,
    output logic signed [OW-1:0] y
);
    generate
        if (POLICY == bfly_pkg::LIM_SAT && OW < IW) begin : g_sat
            localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (OW - 1)) - 1);
            localparam logic signed [IW-1:0] LO = -IW'(64'sd1 <<< (OW - 1));
            logic signed [IW-1:0] clamp;
            always_comb begin
                if (x > HI)      clamp = HI;
                else if (x < LO) clamp = LO;
                else             clamp = x;
                y = clamp[OW-1:0];
            end
        end else if (POLICY == bfly_pkg::LIM_TRUNC && OW < IW) begin : g_trunc
            always_comb y = x[IW-1 -: OW];
        end else begin : g_pass
            always_comb y = x[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/radix2_bfly_core.sv
module radix2_bfly_core #(
    parameter int                    DW    = 8,
    parameter int                    TS    = 7,
    parameter bfly_pkg::stage_mode_e MODE  = bfly_pkg::SM_GENERAL,
    parameter bfly_pkg::limit_e      LIMIT = bfly_pkg::LIM_NONE,
    parameter int                    LIM_W = DW + 1,
    localparam int NW = bfly_pkg::nat_width(MODE, DW),
    localparam int OW = (LIMIT == bfly_pkg::LIM_NONE) ? NW : LIM_W,
    localparam int PW = DW + TS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [PW-1:0] prod_re,
    input  logic signed [PW-1:0] prod_im,
    input  logic                 rot_j,
    output logic                 out_valid,
    output logic signed [OW-1:0] c_re,
    output logic signed [OW-1:0] c_im,
    output logic signed [OW-1:0] d_re,
    output logic signed [OW-1:0] d_im
);
    localparam int NPART = 4;   // c_re, c_im, d_re, d_im

    typedef struct packed {
        logic                 vld;
        logic signed [OW-1:0] cr;
        logic signed [OW-1:0] ci;
        logic signed [OW-1:0] dr;
        logic signed [OW-1:0] di;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [DW:0]    t_re, t_im;
    logic signed [NW-1:0]  raw   [NPART];
    logic signed [OW-1:0]  lim   [NPART];

    bfly_term_gen #(.DW(DW), .TS(TS), .MODE(MODE)) term_i (
        .b_re    (b_re),
        .b_im    (b_im),
        .prod_re (prod_re),
        .prod_im (prod_im),
        .rot_j   (rot_j),
        .t_re    (t_re),
        .t_im    (t_im)
    );

    bfly_addsub #(.DW(DW), .SW(NW)) as_re_i (
        .a     (a_re),
        .t     (t_re),
        .sum_o (raw[0]),
        .dif_o (raw[2])
    );

    bfly_addsub #(.DW(DW), .SW(NW)) as_im_i (
        .a     (a_im),
        .t     (t_im),
        .sum_o (raw[1]),
        .dif_o (raw[3])
    );

    generate
        for (genvar k = 0; k < NPART; k++) begin : g_lim
            bfly_out_limit #(.IW(NW), .OW(OW), .POLICY(LIMIT)) lim_i (
                .x (raw[k]),
                .y (lim[k])
            );
        end
    endgenerate

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = in_valid;
        if (in_valid) begin
            pipe_d.cr = lim[0];
            pipe_d.ci = lim[1];
            pipe_d.dr = lim[2];
            pipe_d.di = lim[3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.vld;
    assign c_re      = pipe_q.cr;
    assign c_im      = pipe_q.ci;
    assign d_re      = pipe_q.dr;
    assign d_im      = pipe_q.di;
endmodule

// File: rtl/bfly_checker.sv
module bfly_checker #(
    parameter int DW      = 8,
    parameter int OW      = 10,
    parameter bit CHK_SUM = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] a_re,
    input logic signed [DW-1:0] a_im,
    input logic                 out_valid,
    input logic signed [OW-1:0] c_re,
    input logic signed [OW-1:0] c_im,
    input logic signed [OW-1:0] d_re,
    input logic signed [OW-1:0] d_im
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> (out_valid == $past(in_valid)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !in_valid) |=> ($stable(c_re) && $stable(c_im)
                                    && $stable(d_re) && $stable(d_im)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && c_re == '0 && d_re == '0));

    generate
        if (CHK_SUM) begin : g_sum
            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && in_valid) |=>
                    ((int'(c_re) + int'(d_re) == 2 * int'($past(a_re)))
                  && (int'(c_im) + int'(d_im) == 2 * int'($past(a_im)))));
        end
    endgenerate
endmodule

bind radix2_bfly_core bfly_checker #(
    .DW      (DW),
    .OW      (OW),
    .CHK_SUM (LIMIT == bfly_pkg::LIM_NONE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_re      (a_re),
    .a_im      (a_im),
    .out_valid (out_valid),
    .c_re      (c_re),
    .c_im      (c_im),
    .d_re      (d_re),
    .d_im      (d_im)
);

// File: tb/radix2_bfly_core_tb_top.sv
`timescale 1ns/100ps
module radix2_bfly_core_tb_top;
    localparam int DW = 8;
    localparam int TS = 7;
    localparam int PW = DW + TS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic rot_j = 1'b0;
    logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [PW-1:0] prod_re = '0, prod_im = '0;

    logic g_v, q_v, u_v;
    logic signed [DW+1:0] g_cr, g_ci, g_dr, g_di;
    logic signed [DW-1:0] q_cr, q_ci, q_dr, q_di;
    logic signed [5:0]    u_cr, u_ci, u_dr, u_di;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    radix2_bfly_core #(.DW(DW), .TS(TS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .prod_re(prod_re), .prod_im(prod_im), .rot_j(rot_j),
        .out_valid(g_v), .c_re(g_cr), .c_im(g_ci), .d_re(g_dr), .d_im(g_di));

    radix2_bfly_core #(.DW(DW), .TS(TS), .MODE(bfly_pkg::SM_QUARTER),
                       .LIMIT(bfly_pkg::LIM_SAT), .LIM_W(8)) dut_q_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .prod_re(prod_re), .prod_im(prod_im), .rot_j(rot_j),
        .out_valid(q_v), .c_re(q_cr), .c_im(q_ci), .d_re(q_dr), .d_im(q_di));

    radix2_bfly_core #(.DW(DW), .TS(TS), .MODE(bfly_pkg::SM_UNITY),
                       .LIMIT(bfly_pkg::LIM_TRUNC), .LIM_W(6)) dut_u_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .prod_re(prod_re), .prod_im(prod_im), .rot_j(rot_j),
        .out_valid(u_v), .c_re(u_cr), .c_im(u_ci), .d_re(u_dr), .d_im(u_di));

    function automatic int sat8(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic verify(string tg, string tq, string tu);
        int ar, ai, br, bi, tr, ti, qr, qi;
        ar = int'(a_re); ai = int'(a_im); br = int'(b_re); bi = int'(b_im);
        tr = int'(prod_re) >>> TS;
        ti = int'(prod_im) >>> TS;
        qr = rot_j ? -bi : br;
        qi = rot_j ? br : bi;
        check("R8", "valid", int'({g_v, q_v, u_v}), 7);
        check(tg, "gen c_re", int'(g_cr), ar + tr);
        check(tg, "gen c_im", int'(g_ci), ai + ti);
        check(tg, "gen d_re", int'(g_dr), ar - tr);
        check(tg, "gen d_im", int'(g_di), ai - ti);
        check(tq, "qtr c_re", int'(q_cr), sat8(ar + qr));
        check(tq, "qtr c_im", int'(q_ci), sat8(ai + qi));
        check(tq, "qtr d_re", int'(q_dr), sat8(ar - qr));
        check(tq, "qtr d_im", int'(q_di), sat8(ai - qi));
        check(tu, "uni c_re", int'(u_cr), (ar + br) >>> 3);
        check(tu, "uni c_im", int'(u_ci), (ai + bi) >>> 3);
        check(tu, "uni d_re", int'(u_dr), (ar - br) >>> 3);
        check(tu, "uni d_im", int'(u_di), (ai - bi) >>> 3);
    endtask

    // Called at a falling edge: presents a sample, waits one edge, checks.
    task automatic put(int ar, int ai, int br, int bi, int pr, int pi, bit rj,
                       string tg, string tq, string tu);
        a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
        prod_re = PW'(pr); prod_im = PW'(pi); rot_j = rj; in_valid = 1'b1;
        @(negedge clk);
        verify(tg, tq, tu);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "valid in reset", int'({g_v, q_v, u_v}), 0);
        check("R10", "gen c_re in reset", int'(g_cr), 0);
        check("R10", "qtr d_im in reset", int'(q_di), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: truncation toward minus infinity
        put(0, 0, 3, -5, -1, 127, 1'b0, "R2", "R5", "R4");
        put(10, -10, -7, 7, -129, 128, 1'b1, "R2", "R5", "R7");
        // R3: full scale without wrap
        put(-128, 127, -128, 127, 32767, -32768, 1'b1, "R3", "R6", "R7");
        put(127, -128, 127, -128, -32768, 32767, 1'b0, "R3", "R6", "R7");
        // R5/R6: j rotation with most negative imaginary part
        put(127, -128, -128, -128, 0, 0, 1'b1, "R1", "R5", "R4");
        put(100, 50, 27, 78, 640, -640, 1'b0, "R1", "R6", "R7");
        // R4: product and rot_j ignored in unity mode
        put(5, 6, 7, 8, 32767, -32768, 1'b1, "R1", "R5", "R4");

        // R9: idle cycle with changed inputs holds outputs
        begin
            int h_gc, h_qd, h_uc;
            h_gc = int'(g_cr); h_qd = int'(q_dr); h_uc = int'(u_ci);
            in_valid = 1'b0;
            a_re = 8'sd99; b_im = -8'sd77; prod_re = 16'sd4000; rot_j = 1'b0;
            @(negedge clk);
            check("R9", "valid after idle", int'({g_v, q_v, u_v}), 0);
            check("R9", "gen c_re held", int'(g_cr), h_gc);
            check("R9", "qtr d_re held", int'(q_dr), h_qd);
            check("R9", "uni c_im held", int'(u_ci), h_uc);
        end

        // R1: random stimulus
        for (int n = 0; n < 300; n++) begin
            put($signed(DW'($urandom)), $signed(DW'($urandom)),
                $signed(DW'($urandom)), $signed(DW'($urandom)),
                $signed(PW'($urandom)), $signed(PW'($urandom)),
                1'($urandom), "R1", "R5", "R4");
        end

        // R10: reset clears after activity
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", "valid after reset", int'({g_v, q_v, u_v}), 0);
        check("R10", "uni d_re after reset", int'(u_dr), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule